// File: doc/BRIEF.md
# Code Segment Base Cache and Fetch Address Generator

This block holds the state of one code segment: the selector that software sees, a hidden base register cached beside it, and a 16-bit instruction pointer. It produces the linear fetch address as the cached base plus the instruction pointer. The cached base changes only when a segment is loaded. It is never derived again from the selector when an address is formed. Because of this, the base that comes out of reset can disagree with the selector that is visible at the same time.

Three requests act on the register set. A segment load writes the selector and the base. A far jump writes the selector, the base and the instruction pointer together. An advance adds a small step to the instruction pointer. A mode input chooses the source of the base on a load. In real mode the base is the selector shifted left by four bits. In protected mode the base is the supplied descriptor base. Changing the mode input on its own does not touch the cached base. A flag output shows whether the special reset base is still in use.

Top module: `segAddrGen`

## Requirements
- R1: After reset, selOut is 0xF000, baseOut is 0xFFFF0000, ipOut is 0xFFF0 and resetBaseLive is 1.
- R2: linAddr always equals (baseOut + ipOut) modulo 2^32, with any carry out discarded. The first fetch address after reset is 0xFFFFFFF0.
- R3: A segment load with protMode=0 sets baseOut to selIn shifted left by 4, zero-extended, from the next cycle.
- R4: A segment load with protMode=1 sets baseOut to descBaseIn from the next cycle, whatever selIn holds.
- R5: When no load and no far jump is requested, baseOut holds its value, including across any number of protMode changes.
- R6: A far jump writes selIn to the selector, the mode-selected base to the base register and jumpIpIn to the instruction pointer, all in the same clock edge. The new linAddr appears in the next cycle.
- R7: An advance with no load and no jump adds advStep (0 to 15) to ipOut modulo 2^16.
- R8: resetBaseLive drops to 0 on the first load or far jump and then stays 0 until the next reset.
- R9: Priority is far jump over segment load over advance. A load in the same cycle as an advance leaves ipOut unchanged. A jump in the same cycle as an advance sets ipOut to jumpIpIn.
- R10: A segment load or far jump sets selOut to selIn from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| protMode | input | 1 | 1 selects the protected-mode base source, 0 selects real mode |
| loadReq | input | 1 | Segment load request |
| jumpReq | input | 1 | Far jump request |
| advReq | input | 1 | Instruction pointer advance request |
| selIn | input | 16 | Selector for a load or jump |
| descBaseIn | input | 32 | Descriptor base, used in protected mode |
| jumpIpIn | input | 16 | Instruction pointer target of a far jump |
| advStep | input | 4 | Advance amount in bytes |
| selOut | output | 16 | Visible selector |
| baseOut | output | 32 | Cached hidden base |
| ipOut | output | 16 | Instruction pointer |
| linAddr | output | 32 | Linear fetch address |
| resetBaseLive | output | 1 | 1 while the reset base is still in use |

## Verification
The properties assume that every request input is a clean 0 or 1 on each rising edge. They also assume that descBaseIn, selIn, jumpIpIn and advStep are stable around that edge, because each load property compares the register against the input value sampled one cycle earlier. The stimulus changes inputs one time unit after a rising edge and releases every request before the next edge. Each request therefore lasts exactly one cycle. The mode is toggled only in cycles where the expected base is already known.

// File: rtl/segPkg.sv
package segPkg;
  typedef struct packed {
    logic wrSel;
    logic wrBase;
    logic useDesc;
    logic wrIp;
    logic advIp;
    logic clrLive;
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic        protMode,
  input  logic        loadReq,
  input  logic        jumpReq,
  input  logic        advReq,
  output segStrobes_t strobes
);
  logic anyLoad;

  always_comb begin
    anyLoad         = loadReq | jumpReq;
    strobes.wrSel   = anyLoad;
    strobes.wrBase  = anyLoad;
    strobes.useDesc = protMode;
    strobes.wrIp    = jumpReq;
    strobes.advIp   = advReq & ~anyLoad;
    strobes.clrLive = anyLoad;
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int IP_W   = 16,
  parameter int STEP_W = 4,
  parameter int SHIFT  = 4,
  parameter logic [SEL_W-1:0]  RST_SEL  = 16'hF000,
  parameter logic [BASE_W-1:0] RST_BASE = 32'hFFFF0000,
  parameter logic [IP_W-1:0]   RST_IP   = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobes_t       strobes,
  input  logic [SEL_W-1:0]  selIn,
  input  logic [BASE_W-1:0] descBaseIn,
  input  logic [IP_W-1:0]   jumpIpIn,
  input  logic [STEP_W-1:0] advStep,
  output logic [SEL_W-1:0]  selOut,
  output logic [BASE_W-1:0] baseOut,
  output logic [IP_W-1:0]   ipOut,
  output logic [BASE_W-1:0] linAddr,
  output logic              resetBaseLive
);
  localparam int PAD_W  = BASE_W - SEL_W - SHIFT;
  localparam int STEP_PAD = IP_W - STEP_W;

  logic [BASE_W-1:0] realBase;
  logic [BASE_W-1:0] nextBase;
  logic [IP_W-1:0]   stepExt;
  logic [IP_W-1:0]   nextIp;

  always_comb begin
    realBase = {{PAD_W{1'b0}}, selIn, {SHIFT{1'b0}}};
    nextBase = strobes.useDesc ? descBaseIn : realBase;
    stepExt  = {{STEP_PAD{1'b0}}, advStep};
    if (strobes.wrIp)       nextIp = jumpIpIn;
    else if (strobes.advIp) nextIp = ipOut + stepExt;
    else                    nextIp = ipOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selOut        <= RST_SEL;
      baseOut       <= RST_BASE;
      ipOut         <= RST_IP;
      resetBaseLive <= 1'b1;
    end else begin
      if (strobes.wrSel)   selOut  <= selIn;
      if (strobes.wrBase)  baseOut <= nextBase;
      ipOut <= nextIp;
      if (strobes.clrLive) resetBaseLive <= 1'b0;
    end
  end

  assign linAddr = baseOut + BASE_W'(ipOut);
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segPkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int IP_W   = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protMode,
  input  logic              loadReq,
  input  logic              jumpReq,
  input  logic              advReq,
  input  logic [SEL_W-1:0]  selIn,
  input  logic [BASE_W-1:0] descBaseIn,
  input  logic [IP_W-1:0]   jumpIpIn,
  input  logic [STEP_W-1:0] advStep,
  output logic [SEL_W-1:0]  selOut,
  output logic [BASE_W-1:0] baseOut,
  output logic [IP_W-1:0]   ipOut,
  output logic [BASE_W-1:0] linAddr,
  output logic              resetBaseLive
);
  segStrobes_t strobes;

  segCtrl u_ctrl (
    .protMode(protMode), .loadReq(loadReq), .jumpReq(jumpReq),
    .advReq(advReq), .strobes(strobes)
  );

  segDatapath #(
    .SEL_W(SEL_W), .BASE_W(BASE_W), .IP_W(IP_W), .STEP_W(STEP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selIn(selIn),
    .descBaseIn(descBaseIn), .jumpIpIn(jumpIpIn), .advStep(advStep),
    .selOut(selOut), .baseOut(baseOut), .ipOut(ipOut),
    .linAddr(linAddr), .resetBaseLive(resetBaseLive)
  );
endmodule

// File: rtl/segChecker.sv
module segChecker #(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int IP_W   = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              protMode,
  input logic              loadReq,
  input logic              jumpReq,
  input logic              advReq,
  input logic [SEL_W-1:0]  selIn,
  input logic [BASE_W-1:0] descBaseIn,
  input logic [IP_W-1:0]   jumpIpIn,
  input logic [STEP_W-1:0] advStep,
  input logic [SEL_W-1:0]  selOut,
  input logic [BASE_W-1:0] baseOut,
  input logic [IP_W-1:0]   ipOut,
  input logic [BASE_W-1:0] linAddr,
  input logic              resetBaseLive
);
  localparam int PAD_W = BASE_W - SEL_W - 4;

  p_real_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !protMode) |=> baseOut == {{PAD_W{1'b0}}, $past(selIn), 4'b0000});

  p_prot_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && protMode) |=> baseOut == $past(descBaseIn));

  p_base_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && !jumpReq) |=> $stable(baseOut));

  p_jump_ip_r6: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |=> ipOut == $past(jumpIpIn));

  p_adv_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (advReq && !loadReq && !jumpReq) |=>
      ipOut == IP_W'($past(ipOut) + IP_W'($past(advStep))));

  p_live_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq || jumpReq) |=> !resetBaseLive);

  p_live_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resetBaseLive |=> !resetBaseLive);

  p_load_prio_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !jumpReq) |=> $stable(ipOut));

  p_sel_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq || jumpReq) |=> selOut == $past(selIn));
endmodule

bind segAddrGen segChecker #(
  .SEL_W(SEL_W), .BASE_W(BASE_W), .IP_W(IP_W), .STEP_W(STEP_W)
) u_chk (.*);

// File: tb/segAddrGen_tb.sv
`timescale 1ns/1ps
module segAddrGen_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, protMode, loadReq, jumpReq, advReq;
  logic [15:0] selIn, jumpIpIn;
  logic [31:0] descBaseIn;
  logic [3:0]  advStep;
  logic [15:0] selOut, ipOut;
  logic [31:0] baseOut, linAddr;
  logic        resetBaseLive;

  segAddrGen u_dut (
    .clk(clk), .rstN(rstN), .protMode(protMode), .loadReq(loadReq),
    .jumpReq(jumpReq), .advReq(advReq), .selIn(selIn),
    .descBaseIn(descBaseIn), .jumpIpIn(jumpIpIn), .advStep(advStep),
    .selOut(selOut), .baseOut(baseOut), .ipOut(ipOut),
    .linAddr(linAddr), .resetBaseLive(resetBaseLive)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit finished = 0;

  longint mSel, mBase, mIp;
  bit mLive;

  task automatic chk(string name, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("selOut", longint'(selOut), mSel);
    chk("baseOut", longint'(baseOut), mBase);
    chk("ipOut", longint'(ipOut), mIp);
    chk("linAddr", longint'(linAddr), (mBase + mIp) % 64'h1_0000_0000);
    chk("resetBaseLive", longint'(resetBaseLive), longint'(mLive));
  endtask

  task automatic stepCycle(bit j, bit l, bit a, logic [15:0] s,
                           logic [31:0] d, logic [15:0] ip, logic [3:0] st);
    jumpReq = j; loadReq = l; advReq = a;
    selIn = s; descBaseIn = d; jumpIpIn = ip; advStep = st;
    @(posedge clk);
    if (j || l) begin
      mSel  = longint'(s);
      mBase = protMode ? longint'(d) : longint'(s) * 16;
      mLive = 0;
      if (j) mIp = longint'(ip);
    end else if (a) begin
      mIp = (mIp + longint'(st)) % 65536;
    end
    #1;
    jumpReq = 0; loadReq = 0; advReq = 0;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    stepCycle(0, 0, 0, 16'h0, 32'h0, 16'h0, 4'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; protMode = 0; loadReq = 0; jumpReq = 0; advReq = 0;
    selIn = 0; descBaseIn = 0; jumpIpIn = 0; advStep = 0;
    mSel = 64'hF000; mBase = 64'hFFFF0000; mIp = 64'hFFF0; mLive = 1;
    repeat (3) @(negedge clk);
    tag = "R1"; compareAll();
    rstN = 1;
    @(negedge clk);
    compareAll();
    tag = "R2"; chk("firstFetch", longint'(linAddr), 64'hFFFFFFF0);

    tag = "R7";
    stepCycle(0, 0, 1, 16'h0, 32'h0, 16'h0, 4'd15);
    stepCycle(0, 0, 1, 16'h0, 32'h0, 16'h0, 4'd2);
    chk("ipWrap", longint'(ipOut), 64'h0001);
    tag = "R5";
    protMode = 1; idle(); protMode = 0; idle();
    chk("resetBaseKept", longint'(baseOut), 64'hFFFF0000);

    tag = "R3";
    stepCycle(0, 1, 0, 16'h1234, 32'hDEADBEEF, 16'h0, 4'h0);
    chk("realBase", longint'(baseOut), 64'h00012340);
    tag = "R8"; chk("liveCleared", longint'(resetBaseLive), 0);
    tag = "R10"; chk("selLoaded", longint'(selOut), 64'h1234);

    tag = "R4"; protMode = 1;
    stepCycle(0, 1, 0, 16'h0008, 32'hFFFFFFF0, 16'h0, 4'h0);
    chk("protBase", longint'(baseOut), 64'hFFFFFFF0);
    tag = "R5"; protMode = 0; idle(); idle();
    chk("protBaseInReal", longint'(baseOut), 64'hFFFFFFF0);

    tag = "R6"; protMode = 0;
    stepCycle(1, 0, 0, 16'h0100, 32'h0, 16'h0020, 4'h0);
    chk("jumpAddr", longint'(linAddr), 64'h00001020);
    protMode = 1;
    stepCycle(1, 0, 0, 16'h0010, 32'hFFFFFFF0, 16'h0020, 4'h0);
    tag = "R2"; chk("carryDropped", longint'(linAddr), 64'h00000010);
    tag = "R5"; protMode = 0; idle();

    tag = "R9";
    stepCycle(0, 1, 1, 16'h0200, 32'h0, 16'h0, 4'd7);
    chk("loadBeatsAdv", longint'(ipOut), 64'h0020);
    stepCycle(1, 1, 1, 16'h0300, 32'h0, 16'h4444, 4'd7);
    chk("jumpBeatsAdv", longint'(ipOut), 64'h4444);

    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if ((i % 37) == 0) protMode = ~protMode;
      stepCycle(r == 0, r == 1 || r == 2, r >= 3, 16'($urandom),
                $urandom, 16'($urandom), 4'($urandom));
    end

    tag = "R1";
    rstN = 0;
    mSel = 64'hF000; mBase = 64'hFFFF0000; mIp = 64'hFFF0; mLive = 1;
    @(negedge clk);
    compareAll();
    rstN = 1;
    tag = "R8"; idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule